// File: doc/BRIEF.md
# Dual-Issue Precise Exception Commit

This block is the retirement point of an in-order, two-wide pipeline. In every cycle the two instructions leaving pipe A and pipe B arrive at it side by side. Each carries a valid bit, a one-bit age tag, an exception flag with a cause code, and its program counter. The block decides which of the two retire, whether a trap is taken, and for which instruction. The result is kept precise whichever pipe holds the older instruction.

The pipe an instruction travels in says nothing about its place in program order. Loads may only run in pipe B, so the older instruction of a pair often sits in pipe B. The age tag carried down the pipe decides the order. A fault-free older instruction in pipe B therefore retires even when the younger instruction in pipe A traps in the same cycle. When the older instruction faults, the younger one is suppressed and the trap reports the older one's cause and PC. A taken trap raises a one-cycle flush that cancels all younger work. This includes the pair that reaches the block while the flush is high.

All results are registered one cycle after the inputs are sampled. A parameter chooses whether the trap cause and PC read as zero when no trap is signalled, or keep the payload of the last trap.

Top module: `dual_issue_commit`

## Requirements
- R1: Commit enables, trap request, trap payload and flush change only at a clock edge. The values seen in cycle n+1 are the block's decision on the inputs sampled at the edge that ends cycle n.
- R2: When both slots are valid and neither has its exception flag set, both commit enables are 1 and no trap is requested.
- R3: When both slots are valid, the slot whose age tag is 1 is the older (A is older if a_age is 1, otherwise B is older). If the older slot is fault-free and the younger slot faults, the older slot commits, the younger does not, and the trap reports the younger slot's cause and PC. This holds whichever pipe holds the older slot.
- R4: When the older valid slot faults, neither slot commits, whether or not the younger slot also faults. The trap reports the older slot's cause and PC.
- R5: When exactly one slot is valid, that slot is treated as the older one whatever its age tag. It commits if fault-free and traps if faulting. The invalid slot never commits.
- R6: flush_young is 1 exactly in the cycles in which trap_req is 1, and it never stays high for two cycles in a row.
- R7: The pair presented during a cycle in which flush_young is 1 is discarded. In the following cycle both commit enables and trap_req are 0.
- R8: A slot whose exception flag is set never has its commit enable asserted for that cycle's decision, and at most one trap is reported per decision.
- R9: With CLEAR_IDLE = 1 (the default), trap_cause and trap_pc read 0 in every cycle in which trap_req is 0.
- R10: While rst_n is 0, every output is 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_valid | input | 1 | Pipe A slot holds an instruction |
| a_age | input | 1 | Pipe A slot is the older of the pair when 1 |
| a_exc | input | 1 | Pipe A instruction raised an exception |
| a_cause | input | CAUSE_W | Pipe A exception cause code |
| a_pc | input | PC_W | Pipe A instruction address |
| b_valid | input | 1 | Pipe B slot holds an instruction |
| b_age | input | 1 | Pipe B slot is the older of the pair when 1 |
| b_exc | input | 1 | Pipe B instruction raised an exception |
| b_cause | input | CAUSE_W | Pipe B exception cause code |
| b_pc | input | PC_W | Pipe B instruction address |
| commit_a | output | 1 | Pipe A instruction retires |
| commit_b | output | 1 | Pipe B instruction retires |
| trap_req | output | 1 | A trap is taken |
| trap_cause | output | CAUSE_W | Cause code of the trapping instruction |
| trap_pc | output | PC_W | Address of the trapping instruction |
| flush_young | output | 1 | Cancel all younger in-flight work |

## Verification
Every result of this block is due exactly one clock after the pair that produced it is sampled. Commit enables, trap request, payload and flush all appear in the cycle after the edge. The discard rule for a pair that arrives under a flush applies to that same next cycle. The bench drives each pair just after a falling edge and checks all outputs at the next falling edge against a behavioural model advanced by one step per edge. It also checks the outputs again one time step after driving new inputs, so any result that follows the inputs without a register is caught as an R1 failure.

// File: rtl/dic_pkg.sv
package dic_pkg;

   localparam int NUM_SLOTS = 2;

   // Slot index; the value is used to index per-slot vectors.
   typedef enum logic {
      SLOT_A = 1'b0,
      SLOT_B = 1'b1
   } slot_e;

   // One cycle's retirement verdict.
   typedef struct packed {
      logic [NUM_SLOTS-1:0] commit;
      logic                 trap;
      slot_e                trap_slot;
   } verdict_t;

   function automatic slot_e other_slot(input slot_e s);
      return (s == SLOT_A) ? SLOT_B : SLOT_A;
   endfunction

endpackage

// File: rtl/dic_slot_qual.sv
// Qualifies one slot: a slot is live when valid and not under a flush;
// it faults when live and flagged.
module dic_slot_qual (
   input  logic in_valid,
   input  logic in_exc,
   input  logic kill,
   output logic live,
   output logic fault
);
   always_comb begin
      live  = in_valid & ~kill;
      fault = live & in_exc;
   end
endmodule

// File: rtl/dic_age_pick.sv
// Resolves which live slot is older from the carried age tag.
module dic_age_pick
   import dic_pkg::*;
#(
   parameter int SLOTS = NUM_SLOTS
) (
   input  logic [SLOTS-1:0] live,
   input  logic             a_age,
   output slot_e            old_slot,
   output logic             old_live,
   output logic             young_live
);
   localparam int SLOT_BITS = $clog2(SLOTS);

   if (SLOTS != 2) begin : g_bad_slots
      $error("dic_age_pick supports exactly two slots");
   end
   if (SLOT_BITS != 1) begin : g_bad_bits
      $error("dic_age_pick slot index must be one bit");
   end

   always_comb begin
      old_slot   = SLOT_A;
      old_live   = 1'b0;
      young_live = 1'b0;
      unique case (live)
         2'b11: begin
            old_slot   = a_age ? SLOT_A : SLOT_B;
            old_live   = 1'b1;
            young_live = 1'b1;
         end
         2'b01: begin
            old_slot = SLOT_A;
            old_live = 1'b1;
         end
         2'b10: begin
            old_slot = SLOT_B;
            old_live = 1'b1;
         end
         default: begin
            old_slot = SLOT_A;
         end
      endcase
   end
endmodule

// File: rtl/dic_resolve.sv
// Turns age order and per-slot faults into a retirement verdict.
module dic_resolve
   import dic_pkg::*;
#(
   parameter int SLOTS = NUM_SLOTS
) (
   input  slot_e            old_slot,
   input  logic             old_live,
   input  logic             young_live,
   input  logic [SLOTS-1:0] fault,
   output verdict_t         verdict
);
   slot_e young_slot;
   logic  old_fault;
   logic  young_fault;

   always_comb begin
      young_slot  = other_slot(old_slot);
      old_fault   = fault[old_slot];
      young_fault = fault[young_slot];
   end

   always_comb begin
      verdict = '0;
      if (old_live) begin
         if (old_fault) begin
            verdict.trap      = 1'b1;
            verdict.trap_slot = old_slot;
         end else begin
            verdict.commit[old_slot] = 1'b1;
            if (young_live) begin
               if (young_fault) begin
                  verdict.trap      = 1'b1;
                  verdict.trap_slot = young_slot;
               end else begin
                  verdict.commit[young_slot] = 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dual_issue_commit.sv
module dual_issue_commit
   import dic_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int CAUSE_W    = 5,
   parameter bit CLEAR_IDLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               a_valid,
   input  logic               a_age,
   input  logic               a_exc,
   input  logic [CAUSE_W-1:0] a_cause,
   input  logic [PC_W-1:0]    a_pc,
   input  logic               b_valid,
   input  logic               b_age,
   input  logic               b_exc,
   input  logic [CAUSE_W-1:0] b_cause,
   input  logic [PC_W-1:0]    b_pc,
   output logic               commit_a,
   output logic               commit_b,
   output logic               trap_req,
   output logic [CAUSE_W-1:0] trap_cause,
   output logic [PC_W-1:0]    trap_pc,
   output logic               flush_young
);
   localparam int SLOTS     = NUM_SLOTS;
   localparam int PAYLOAD_W = CAUSE_W + PC_W;

   if (PC_W < 2) begin : g_bad_pc
      $error("PC_W must be at least 2");
   end
   if (CAUSE_W < 1) begin : g_bad_cause
      $error("CAUSE_W must be at least 1");
   end

   logic [SLOTS-1:0]     in_valid;
   logic [SLOTS-1:0]     in_exc;
   logic [PAYLOAD_W-1:0] in_payload [SLOTS];
   logic [SLOTS-1:0]     live;
   logic [SLOTS-1:0]     fault;
   logic                 kill;

   slot_e    old_slot;
   logic     old_live;
   logic     young_live;
   verdict_t verdict;

   logic [SLOTS-1:0]     commit_q;
   logic                 trap_q;
   logic                 flush_q;
   logic [PAYLOAD_W-1:0] payload_q;
   logic [PAYLOAD_W-1:0] sel_payload;

   // b_age carries the complement of a_age for a full pair; a_age decides.
   logic b_age_seen;
   assign b_age_seen = b_age;

   always_comb begin
      in_valid      = {b_valid, a_valid};
      in_exc        = {b_exc, a_exc};
      in_payload[0] = {a_cause, a_pc};
      in_payload[1] = {b_cause, b_pc};
      kill          = flush_q;
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      dic_slot_qual u_qual (
         .in_valid (in_valid[s]),
         .in_exc   (in_exc[s]),
         .kill     (kill),
         .live     (live[s]),
         .fault    (fault[s])
      );
   end

   dic_age_pick #(.SLOTS(SLOTS)) u_age (
      .live       (live),
      .a_age      (a_age),
      .old_slot   (old_slot),
      .old_live   (old_live),
      .young_live (young_live)
   );

   dic_resolve #(.SLOTS(SLOTS)) u_resolve (
      .old_slot   (old_slot),
      .old_live   (old_live),
      .young_live (young_live),
      .fault      (fault),
      .verdict    (verdict)
   );

   always_comb begin
      sel_payload = in_payload[verdict.trap_slot];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_q <= '0;
         trap_q   <= 1'b0;
         flush_q  <= 1'b0;
      end else begin
         commit_q <= verdict.commit;
         trap_q   <= verdict.trap;
         flush_q  <= verdict.trap;
      end
   end

   if (CLEAR_IDLE) begin : g_payload_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            payload_q <= '0;
         end else if (verdict.trap) begin
            payload_q <= sel_payload;
         end else begin
            payload_q <= '0;
         end
      end
   end else begin : g_payload_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            payload_q <= '0;
         end else if (verdict.trap) begin
            payload_q <= sel_payload;
         end
      end
   end

   always_comb begin
      commit_a    = commit_q[SLOT_A];
      commit_b    = commit_q[SLOT_B];
      trap_req    = trap_q;
      flush_young = flush_q;
      trap_cause  = payload_q[PAYLOAD_W-1:PC_W];
      trap_pc     = payload_q[PC_W-1:0];
   end
endmodule

// File: rtl/dual_issue_commit_chk.sv
module dual_issue_commit_chk #(
   parameter int PC_W       = 32,
   parameter int CAUSE_W    = 5,
   parameter bit CLEAR_IDLE = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               a_valid,
   input logic               a_age,
   input logic               a_exc,
   input logic [CAUSE_W-1:0] a_cause,
   input logic [PC_W-1:0]    a_pc,
   input logic               b_valid,
   input logic               b_age,
   input logic               b_exc,
   input logic [CAUSE_W-1:0] b_cause,
   input logic [PC_W-1:0]    b_pc,
   input logic               commit_a,
   input logic               commit_b,
   input logic               trap_req,
   input logic [CAUSE_W-1:0] trap_cause,
   input logic [PC_W-1:0]    trap_pc,
   input logic               flush_young
);
   // R3: a full pair carries exactly one older tag.
   a_r3_one_older_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && b_valid) |-> (a_age != b_age));

   // R1: a commit needs a valid slot on the previous edge.
   a_r1_commit_a_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
      commit_a |-> $past(a_valid));
   a_r1_commit_b_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
      commit_b |-> $past(b_valid));

   // R2: clean pair retires in full.
   a_r2_clean_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_young && a_valid && b_valid && !a_exc && !b_exc)
      |=> (commit_a && commit_b && !trap_req));

   // R3: older in B, younger in A faults.
   a_r3_older_b_retires: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_young && a_valid && b_valid && !a_age && !b_exc && a_exc)
      |=> (commit_b && !commit_a && trap_req && trap_pc == $past(a_pc)
           && trap_cause == $past(a_cause)));

   // R4: older in A faults, younger suppressed.
   a_r4_older_a_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_young && a_valid && b_valid && a_age && a_exc)
      |=> (!commit_a && !commit_b && trap_req && trap_pc == $past(a_pc)));
   a_r4_older_b_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_young && a_valid && b_valid && !a_age && b_exc)
      |=> (!commit_a && !commit_b && trap_req && trap_pc == $past(b_pc)));

   // R5: lone slot is oldest whatever its tag.
   a_r5_lone_b: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_young && !a_valid && b_valid && !b_exc)
      |=> (commit_b && !commit_a && !trap_req));

   // R6: flush tracks trap and is a single-cycle pulse.
   a_r6_flush_is_trap: assert property (@(posedge clk) disable iff (!rst_n)
      flush_young == trap_req);
   a_r6_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      flush_young |=> !flush_young);

   // R7: pair arriving under flush is discarded.
   a_r7_drop_under_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush_young |=> (!commit_a && !commit_b && !trap_req));

   // R8: a flagged slot never commits.
   a_r8_fault_a_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      a_exc |=> !commit_a);
   a_r8_fault_b_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      b_exc |=> !commit_b);

   // R9: idle payload reads zero.
   if (CLEAR_IDLE) begin : g_idle
      a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !trap_req |-> (trap_pc == '0 && trap_cause == '0));
   end

   // R10: reset clears outputs.
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r10_reset_quiet: assert (!commit_a && !commit_b && !trap_req && !flush_young);
      end
   end
endmodule

bind dual_issue_commit dual_issue_commit_chk #(
   .PC_W       (PC_W),
   .CAUSE_W    (CAUSE_W),
   .CLEAR_IDLE (CLEAR_IDLE)
) u_chk (.*);

// File: tb/dual_issue_commit_test.sv
module dual_issue_commit_test;
   localparam int CLK_PERIOD = 10;
   localparam int PC_W       = 32;
   localparam int CAUSE_W    = 5;
   localparam int WATCHDOG   = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_valid = 0, a_age = 0, a_exc = 0;
   logic b_valid = 0, b_age = 0, b_exc = 0;
   logic [CAUSE_W-1:0] a_cause = '0, b_cause = '0;
   logic [PC_W-1:0]    a_pc = '0, b_pc = '0;
   logic commit_a, commit_b, trap_req, flush_young;
   logic [CAUSE_W-1:0] trap_cause;
   logic [PC_W-1:0]    trap_pc;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Reference expectations (value due at the next falling edge).
   logic e_ca = 0, e_cb = 0, e_trap = 0, e_flush = 0;
   logic [CAUSE_W-1:0] e_cause = '0;
   logic [PC_W-1:0]    e_pc = '0;
   string e_tag = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_issue_commit #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .a_valid(a_valid), .a_age(a_age), .a_exc(a_exc), .a_cause(a_cause), .a_pc(a_pc),
      .b_valid(b_valid), .b_age(b_age), .b_exc(b_exc), .b_cause(b_cause), .b_pc(b_pc),
      .commit_a(commit_a), .commit_b(commit_b), .trap_req(trap_req),
      .trap_cause(trap_cause), .trap_pc(trap_pc), .flush_young(flush_young)
   );

   task automatic chk(input string tag, input string what, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "commit_a", commit_a, e_ca);
      chk(tag, "commit_b", commit_b, e_cb);
      chk(tag, "trap_req", trap_req, e_trap);
      chk("R6", "flush_young", flush_young, e_flush);
      if (e_trap) begin
         chk(tag, "trap_cause", trap_cause, e_cause);
         chk(tag, "trap_pc", trap_pc, e_pc);
      end else begin
         chk("R9", "idle trap_cause", trap_cause, 0);
         chk("R9", "idle trap_pc", trap_pc, 0);
      end
   endtask

   // Behavioural model of one decision.
   task automatic predict();
      bit v[2], x[2];
      logic [CAUSE_W-1:0] c[2];
      logic [PC_W-1:0] p[2];
      int o, y;
      bit kill;
      v[0] = a_valid; v[1] = b_valid;
      x[0] = a_exc;   x[1] = b_exc;
      c[0] = a_cause; c[1] = b_cause;
      p[0] = a_pc;    p[1] = b_pc;
      kill = e_flush;
      e_ca = 0; e_cb = 0; e_trap = 0; e_cause = '0; e_pc = '0;
      o = -1; y = -1;
      if (v[0] && v[1]) begin o = a_age ? 0 : 1; y = 1 - o; end
      else if (v[0]) o = 0;
      else if (v[1]) o = 1;
      if (kill) begin
         e_tag = "R7";
      end else if (o < 0) begin
         e_tag = "R2";
      end else if (x[o]) begin
         e_trap = 1; e_cause = c[o]; e_pc = p[o];
         e_tag = (y >= 0) ? "R4" : "R5";
      end else begin
         if (o == 0) e_ca = 1; else e_cb = 1;
         if (y >= 0) begin
            if (x[y]) begin
               e_trap = 1; e_cause = c[y]; e_pc = p[y]; e_tag = "R3";
            end else begin
               if (y == 0) e_ca = 1; else e_cb = 1;
               e_tag = "R2";
            end
         end else begin
            e_tag = "R5";
         end
      end
      e_flush = e_trap;
   endtask

   // One cycle: check due results, drive new pair, confirm no combinational path (R1).
   task automatic step(input bit av, input bit aa, input bit ae, input int ac, input int ap,
                       input bit bv, input bit ba, input bit be, input int bc, input int bp);
      @(negedge clk);
      check_all(e_tag);
      a_valid = av; a_age = aa; a_exc = ae; a_cause = CAUSE_W'(ac); a_pc = PC_W'(ap);
      b_valid = bv; b_age = ba; b_exc = be; b_cause = CAUSE_W'(bc); b_pc = PC_W'(bp);
      #1;
      check_all("R1");
      predict();
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R10: busy faulting inputs during reset, outputs stay zero.
      a_valid = 1; a_exc = 1; a_age = 1; a_pc = 32'h100; b_valid = 1; b_age = 0;
      repeat (3) begin
         @(negedge clk);
         check_all("R10");
      end
      @(negedge clk);
      rst_n = 1;
      a_valid = 0; b_valid = 0; a_exc = 0;
      predict();

      // R2: clean pairs, both orders.
      step(1,1,0,0,'h1000, 1,0,0,0,'h1004);
      step(1,0,0,0,'h2004, 1,1,0,0,'h2000);
      // R3: load older in B, younger A raises a system call.
      step(1,0,1,8,'h3004, 1,1,0,0,'h3000);
      step(0,0,0,0,0, 0,0,0,0,0);            // R7: arrives under flush
      // R3: older in A, younger B misaligned.
      step(1,1,0,0,'h4000, 1,0,1,4,'h4004);
      step(1,1,0,0,'h4100, 1,0,0,0,'h4104);  // R7: live pair discarded
      // R4: older B faults, younger A faults too.
      step(1,0,1,8,'h5004, 1,1,1,13,'h5000);
      step(0,0,0,0,0, 0,0,0,0,0);
      // R4: older A faults, younger B clean.
      step(1,1,1,11,'h6000, 1,0,0,0,'h6004);
      step(0,0,0,0,0, 0,0,0,0,0);
      // R5: lone slots with tag 0.
      step(0,0,0,0,0, 1,0,0,0,'h7000);
      step(1,0,0,0,'h7100, 0,0,0,0,0);
      step(0,0,0,0,0, 1,0,1,6,'h7200);
      step(0,0,0,0,0, 0,0,0,0,0);
      step(1,0,1,2,'h7300, 0,1,1,9,'h7304);   // R5/R8: invalid B faulting ignored
      step(0,0,0,0,0, 0,0,0,0,0);
      // R9: idle bubbles.
      step(0,0,0,0,0, 0,0,0,0,0);

      // Mixed traffic (R2..R9).
      for (int i = 0; i < 3000; i++) begin
         bit av, bv, aa, ba, ae, be;
         av = ($urandom % 4) != 0;
         bv = ($urandom % 4) != 0;
         aa = $urandom % 2;
         ba = (av && bv) ? !aa : bit'($urandom % 2);
         ae = ($urandom % 4) == 0;
         be = ($urandom % 4) == 0;
         step(av, aa, ae, int'($urandom % 32), int'($urandom),
              bv, ba, be, int'($urandom % 32), int'($urandom));
      end
      @(negedge clk);
      check_all(e_tag);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule